// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose procedure calls slide a window over a larger physical store. Software always sees 32 registers, numbered by a 5-bit index and sorted into four classes of eight: one global set shared by every procedure, plus an out set, a local set and an in set that belong to the current window. The physical store keeps the eight globals and sixteen registers per window (its outs and its locals). The ins of one window are the same flops as the outs of its neighbour, so arguments placed in the caller's outs appear in the callee's ins without any copying.

A save command moves the window pointer down by one (modulo the number of windows). The callee then sees the caller's outs as its ins and gets a locals and outs set of its own. A restore command moves the pointer back. A counter tracks how many windows are resident. When a save would need one more window than the store can hold, or a restore would leave no window behind, the pointer stays put and a one-cycle trap request is raised instead, so that a handler can spill or refill windows. Two reads are combinational and one write is clocked, all addressed in the current window.

Top module: `winreg_file`

## Requirements
- R1: Index bits [4:3] select the register class: 0 global, 1 out, 2 local, 3 in; bits [2:0] pick the register inside the class. A value written to an index is returned on both read ports for that index in the same window from the cycle after the write.
- R2: Reading index 0 always returns zero, and a write to index 0 leaves every register unchanged.
- R3: The globals (indices 1 to 7) are one set. A value written in any window reads back the same in every other window.
- R4: A save taken with fewer than NWIN-1 windows resident moves the pointer to (cwp-1) mod NWIN and adds one to the resident count. After it, in register k (index 24+k) returns what out register k (index 8+k) held before the save, including out 7 seen as in 7.
- R5: After a save into a window not written since reset, its locals and outs read zero, and writes to them do not change the caller's locals or outs.
- R6: A restore taken with more than one window resident moves the pointer to (cwp+1) mod NWIN, subtracts one from the count, and the caller's locals and outs read as they were before the save.
- R7: A save with NWIN-1 windows resident leaves the pointer and the count unchanged, and overflow trap is high for exactly the next cycle.
- R8: A restore with one window resident leaves the pointer and the count unchanged, and underflow trap is high for exactly the next cycle.
- R9: A write that comes in the same cycle as a save or restore goes to the window current before the move. Reads in that cycle use the old window.
- R10: When save and restore come in the same cycle, the save is carried out and the restore is ignored.
- R11: After reset the pointer is 0, the count is 1, both trap requests are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rs1_idx_i | input | 5 | Architectural index of read port A |
| rs1_data_o | output | DW | Read port A data (combinational) |
| rs2_idx_i | input | 5 | Architectural index of read port B |
| rs2_data_o | output | DW | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Architectural index to write |
| wr_data_i | input | DW | Write data |
| save_i | input | 1 | Save command: open a new window |
| restore_i | input | 1 | Restore command: return to the previous window |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| used_o | output | $clog2(NWIN) | Number of resident windows |
| ovf_trap_o | output | 1 | Overflow trap request, one-cycle pulse |
| unf_trap_o | output | 1 | Underflow trap request, one-cycle pulse |

## Verification
A register write and a window move can fall in the same cycle, and so can a save and a restore. The directed part writes a local together with a restore, then saves back into that window and reads the local. It also asserts save and restore together and checks that the pointer moved down. The random part sets writes, saves and restores independently each cycle, so these collisions also happen close to the full and empty limits. Every read and every pointer, count and trap value is judged against a bench model that applies the write with the old pointer before it moves the pointer.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam int ARCH_IDX_W = 5;
    localparam int CLASS_SIZE = 8;
    localparam int SUB_W      = 3;
    localparam int WIN_REGS   = 2 * CLASS_SIZE;

    typedef enum logic [1:0] {
        CLS_GLOBAL = 2'd0,
        CLS_OUT    = 2'd1,
        CLS_LOCAL  = 2'd2,
        CLS_IN     = 2'd3
    } reg_class_e;

    function automatic reg_class_e class_of(input logic [ARCH_IDX_W-1:0] idx);
        return reg_class_e'(idx[ARCH_IDX_W-1:SUB_W]);
    endfunction

endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
    parameter int NWIN = 8
) (
    input  logic [$clog2(NWIN)-1:0]                  cwp_i,
    input  logic [winreg_pkg::ARCH_IDX_W-1:0]        idx_i,
    output logic                                     is_glob_o,
    output logic [winreg_pkg::SUB_W-1:0]             gsel_o,
    output logic [$clog2(NWIN*winreg_pkg::WIN_REGS)-1:0] wsel_o
);
    import winreg_pkg::*;

    localparam int PW     = $clog2(NWIN);
    localparam int WSEL_W = $clog2(NWIN * WIN_REGS);
    localparam int WIN_SH = $clog2(WIN_REGS);

    logic [PW-1:0]     win_above;
    logic [PW-1:0]     win_sel;
    logic              half_sel;
    reg_class_e        cls;

    always_comb begin
        cls       = class_of(idx_i);
        win_above = (cwp_i == PW'(NWIN - 1)) ? '0 : cwp_i + PW'(1);
        is_glob_o = (cls == CLS_GLOBAL);
        gsel_o    = idx_i[SUB_W-1:0];
        win_sel   = cwp_i;
        half_sel  = 1'b0;
        unique case (cls)
            CLS_GLOBAL: begin win_sel = cwp_i;     half_sel = 1'b0; end
            CLS_OUT:    begin win_sel = cwp_i;     half_sel = 1'b0; end
            CLS_LOCAL:  begin win_sel = cwp_i;     half_sel = 1'b1; end
            CLS_IN:     begin win_sel = win_above; half_sel = 1'b0; end
            default:    begin win_sel = cwp_i;     half_sel = 1'b0; end
        endcase
        wsel_o = (WSEL_W'(win_sel) << WIN_SH)
               | (WSEL_W'(half_sel) << SUB_W)
               | WSEL_W'(idx_i[SUB_W-1:0]);
    end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
    parameter int NWIN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    save_i,
    input  logic                    restore_i,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic [$clog2(NWIN)-1:0] used_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int PW = $clog2(NWIN);
    localparam logic [PW-1:0] USED_MAX = PW'(NWIN - 1);
    localparam logic [PW-1:0] USED_MIN = PW'(1);

    typedef struct packed {
        logic [PW-1:0] cwp;
        logic [PW-1:0] used;
        logic          ovf;
        logic          unf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  do_save, do_restore;

    always_comb begin
        st_d       = st_q;
        st_d.ovf   = 1'b0;
        st_d.unf   = 1'b0;
        do_save    = 1'b0;
        do_restore = 1'b0;
        if (save_i) begin
            if (st_q.used == USED_MAX) begin
                st_d.ovf = 1'b1;
            end else begin
                do_save = 1'b1;
            end
        end else if (restore_i) begin
            if (st_q.used == USED_MIN) begin
                st_d.unf = 1'b1;
            end else begin
                do_restore = 1'b1;
            end
        end
        if (do_save) begin
            st_d.cwp  = (st_q.cwp == '0) ? PW'(NWIN - 1) : st_q.cwp - PW'(1);
            st_d.used = st_q.used + PW'(1);
        end
        if (do_restore) begin
            st_d.cwp  = (st_q.cwp == PW'(NWIN - 1)) ? '0 : st_q.cwp + PW'(1);
            st_d.used = st_q.used - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cwp: '0, used: USED_MIN, ovf: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cwp_o  = st_q.cwp;
    assign used_o = st_q.used;
    assign ovf_o  = st_q.ovf;
    assign unf_o  = st_q.unf;

endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    parameter int NRD  = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          we_i,
    input  logic                                          wr_glob_i,
    input  logic [winreg_pkg::SUB_W-1:0]                  wr_gsel_i,
    input  logic [$clog2(NWIN*winreg_pkg::WIN_REGS)-1:0]  wr_wsel_i,
    input  logic [DW-1:0]                                 wr_data_i,
    input  logic [NRD-1:0]                                rd_glob_i,
    input  logic [NRD-1:0][winreg_pkg::SUB_W-1:0]         rd_gsel_i,
    input  logic [NRD-1:0][$clog2(NWIN*winreg_pkg::WIN_REGS)-1:0] rd_wsel_i,
    output logic [NRD-1:0][DW-1:0]                        rd_data_o
);
    import winreg_pkg::*;

    localparam int NPHYS = NWIN * WIN_REGS;

    logic [DW-1:0] glob_d [CLASS_SIZE];
    logic [DW-1:0] glob_q [CLASS_SIZE];
    logic [DW-1:0] win_d  [NPHYS];
    logic [DW-1:0] win_q  [NPHYS];

    always_comb begin
        glob_d = glob_q;
        win_d  = win_q;
        if (we_i) begin
            if (wr_glob_i) begin
                if (wr_gsel_i != '0) begin
                    glob_d[wr_gsel_i] = wr_data_i;
                end
            end else begin
                win_d[wr_wsel_i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < CLASS_SIZE; g++) glob_q[g] <= '0;
            for (int p = 0; p < NPHYS; p++)      win_q[p]  <= '0;
        end else begin
            glob_q <= glob_d;
            win_q  <= win_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        always_comb begin
            if (rd_glob_i[r]) begin
                rd_data_o[r] = (rd_gsel_i[r] == '0) ? '0 : glob_q[rd_gsel_i[r]];
            end else begin
                rd_data_o[r] = win_q[rd_wsel_i[r]];
            end
        end
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int DW   = 32,
    parameter int NWIN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rs1_idx_i,
    output logic [DW-1:0]           rs1_data_o,
    input  logic [4:0]              rs2_idx_i,
    output logic [DW-1:0]           rs2_data_o,
    input  logic                    wr_en_i,
    input  logic [4:0]              wr_idx_i,
    input  logic [DW-1:0]           wr_data_i,
    input  logic                    save_i,
    input  logic                    restore_i,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic [$clog2(NWIN)-1:0] used_o,
    output logic                    ovf_trap_o,
    output logic                    unf_trap_o
);
    import winreg_pkg::*;

    localparam int PW     = $clog2(NWIN);
    localparam int WSEL_W = $clog2(NWIN * WIN_REGS);
    localparam int NRD    = 2;
    localparam int NPORT  = NRD + 1;

    logic [PW-1:0]                 cwp;
    logic [NPORT-1:0][4:0]         port_idx;
    logic [NPORT-1:0]              port_glob;
    logic [NPORT-1:0][SUB_W-1:0]   port_gsel;
    logic [NPORT-1:0][WSEL_W-1:0]  port_wsel;
    logic [NRD-1:0][DW-1:0]        rd_data;

    winreg_ctrl #(.NWIN(NWIN)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (save_i),
        .restore_i (restore_i),
        .cwp_o     (cwp),
        .used_o    (used_o),
        .ovf_o     (ovf_trap_o),
        .unf_o     (unf_trap_o)
    );

    assign port_idx[0] = rs1_idx_i;
    assign port_idx[1] = rs2_idx_i;
    assign port_idx[2] = wr_idx_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        winreg_map #(.NWIN(NWIN)) map_i (
            .cwp_i     (cwp),
            .idx_i     (port_idx[p]),
            .is_glob_o (port_glob[p]),
            .gsel_o    (port_gsel[p]),
            .wsel_o    (port_wsel[p])
        );
    end

    winreg_store #(.DW(DW), .NWIN(NWIN), .NRD(NRD)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i),
        .wr_glob_i (port_glob[2]),
        .wr_gsel_i (port_gsel[2]),
        .wr_wsel_i (port_wsel[2]),
        .wr_data_i (wr_data_i),
        .rd_glob_i (port_glob[NRD-1:0]),
        .rd_gsel_i (port_gsel[NRD-1:0]),
        .rd_wsel_i (port_wsel[NRD-1:0]),
        .rd_data_o (rd_data)
    );

    assign rs1_data_o = rd_data[0];
    assign rs2_data_o = rd_data[1];
    assign cwp_o      = cwp;

endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
    parameter int DW   = 32,
    parameter int NWIN = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4:0]              rs1_idx_i,
    input logic [DW-1:0]           rs1_data_o,
    input logic [4:0]              rs2_idx_i,
    input logic [DW-1:0]           rs2_data_o,
    input logic                    save_i,
    input logic                    restore_i,
    input logic [$clog2(NWIN)-1:0] cwp_o,
    input logic [$clog2(NWIN)-1:0] used_o,
    input logic                    ovf_trap_o,
    input logic                    unf_trap_o
);
    localparam int PW = $clog2(NWIN);
    localparam logic [PW-1:0] UMAX = PW'(NWIN - 1);

    logic [PW-1:0] cwp_dn, cwp_up;
    always_comb begin
        cwp_dn = (cwp_o == '0) ? UMAX : cwp_o - PW'(1);
        cwp_up = (cwp_o == UMAX) ? '0 : cwp_o + PW'(1);
    end

    a_r2_g0_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx_i == 5'd0) |-> (rs1_data_o == '0));
    a_r2_g0_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rs2_idx_i == 5'd0) |-> (rs2_data_o == '0));
    a_r4_save_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && used_o != UMAX) |=> (cwp_o == $past(cwp_dn) && used_o == $past(used_o) + PW'(1)));
    a_r6_restore_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_i && restore_i && used_o != PW'(1)) |=> (cwp_o == $past(cwp_up) && used_o == $past(used_o) - PW'(1)));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && used_o == UMAX) |=> (ovf_trap_o && $stable(cwp_o) && $stable(used_o)));
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_i && restore_i && used_o == PW'(1)) |=> (unf_trap_o && $stable(cwp_o) && $stable(used_o)));
    a_r10_one_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap_o, unf_trap_o}));
    a_r11_used_range: assert property (@(posedge clk) disable iff (!rst_n)
        (used_o >= PW'(1) && used_o <= UMAX));

endmodule

bind winreg_file winreg_file_chk #(.DW(DW), .NWIN(NWIN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rs1_idx_i  (rs1_idx_i),
    .rs1_data_o (rs1_data_o),
    .rs2_idx_i  (rs2_idx_i),
    .rs2_data_o (rs2_data_o),
    .save_i     (save_i),
    .restore_i  (restore_i),
    .cwp_o      (cwp_o),
    .used_o     (used_o),
    .ovf_trap_o (ovf_trap_o),
    .unf_trap_o (unf_trap_o)
);

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NW = 8;
    localparam int NSLOT = 8 + NW * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rs1_idx = '0, rs2_idx = '0, wr_idx = '0;
    logic [DW-1:0] rs1_data, rs2_data, wr_data = '0;
    logic          wr_en = 1'b0, save = 1'b0, restore = 1'b0;
    logic [2:0]    cwp, used;
    logic          ovf, unf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [DW-1:0] mem [NSLOT];
    int mcwp, mused;

    always #(CLK_PERIOD/2) clk = ~clk;

    winreg_file #(.DW(DW), .NWIN(NW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rs1_idx_i(rs1_idx), .rs1_data_o(rs1_data),
        .rs2_idx_i(rs2_idx), .rs2_data_o(rs2_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .save_i(save), .restore_i(restore),
        .cwp_o(cwp), .used_o(used),
        .ovf_trap_o(ovf), .unf_trap_o(unf)
    );

    function automatic int slot(int w, int idx);
        if (idx < 8)  return idx;
        if (idx < 16) return 8 + w * 16 + (idx - 8);
        if (idx < 24) return 8 + w * 16 + 8 + (idx - 16);
        return 8 + ((w + 1) % NW) * 16 + (idx - 24);
    endfunction

    function automatic logic [DW-1:0] mread(int idx);
        if (idx == 0) return '0;
        return mem[slot(mcwp, idx)];
    endfunction

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(string req, int a, int b, bit we, int widx, logic [DW-1:0] wd, bit sv, bit rs);
        bit eo, eu;
        rs1_idx = 5'(a); rs2_idx = 5'(b);
        wr_en = we; wr_idx = 5'(widx); wr_data = wd;
        save = sv; restore = rs;
        #1;
        chk(req, "read A", rs1_data, mread(a));
        chk(req, "read B", rs2_data, mread(b));
        // write lands in the window current before any move (R9)
        if (we && widx != 0) mem[slot(mcwp, widx)] = wd;
        eo = 0; eu = 0;
        if (sv) begin
            if (mused == NW - 1) eo = 1;
            else begin mcwp = (mcwp + NW - 1) % NW; mused++; end
        end else if (rs) begin
            if (mused == 1) eu = 1;
            else begin mcwp = (mcwp + 1) % NW; mused--; end
        end
        @(posedge clk); #1;
        chk("R7", "overflow trap", DW'(ovf), DW'(eo));
        chk("R8", "underflow trap", DW'(unf), DW'(eu));
        chk(req, "window pointer", DW'(cwp), DW'(mcwp));
        chk(req, "resident count", DW'(used), DW'(mused));
        wr_en = 0; save = 0; restore = 0;
    endtask

    task automatic rd(string req, int a, int b);
        step(req, a, b, 0, 0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) mem[i] = '0;
        mcwp = 0; mused = 1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2) rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "pointer", DW'(cwp), 0);
        chk("R11", "count", DW'(used), 1);
        chk("R11", "traps", DW'({ovf, unf}), 0);
        rs1_idx = 5'd13; rs2_idx = 5'd30; #1;
        chk("R11", "reg 13", rs1_data, '0);
        chk("R11", "reg 30", rs2_data, '0);
        @(posedge clk); #1;

        // R1 each class written and read back
        step("R1", 0, 0, 1, 1,  32'h1111_0001, 0, 0);
        step("R1", 1, 0, 1, 11, 32'h2222_000B, 0, 0);
        step("R1", 11, 1, 1, 21, 32'h3333_0015, 0, 0);
        step("R1", 21, 11, 1, 26, 32'h4444_001A, 0, 0);
        rd("R1", 26, 21);
        chk("R1", "in 2 literal", rs1_data, 32'h4444_001A);

        // R2 write to index 0 discarded
        step("R2", 0, 1, 1, 0, 32'hDEAD_BEEF, 0, 0);
        rd("R2", 0, 0);
        chk("R2", "g0 after write", rs1_data, '0);

        // R4 out 7 becomes in 7 after save
        step("R4", 0, 0, 1, 15, 32'h7777_0007, 0, 0);
        step("R4", 15, 11, 0, 0, '0, 1, 0);
        rd("R4", 31, 27);
        chk("R4", "in7 literal", rs1_data, 32'h7777_0007);
        chk("R4", "in3 literal", rs2_data, 32'h2222_000B);

        // R5 fresh locals and outs; writes stay in callee
        rd("R5", 21, 11);
        chk("R5", "fresh local", rs1_data, '0);
        step("R5", 0, 0, 1, 21, 32'h5555_0005, 0, 0);
        // R3 global visible in new window
        rd("R3", 1, 21);
        chk("R3", "global in callee", rs1_data, 32'h1111_0001);
        step("R3", 0, 0, 1, 2, 32'h6666_0002, 0, 0);

        // R9 write with restore lands in callee window
        step("R9", 21, 0, 1, 20, 32'h9999_0014, 0, 1);
        rd("R6", 21, 11);
        chk("R6", "caller local back", rs1_data, 32'h3333_0015);
        chk("R6", "caller out back", rs2_data, 32'h2222_000B);
        rd("R3", 2, 0);
        chk("R3", "global from callee", rs1_data, 32'h6666_0002);
        step("R9", 0, 0, 0, 0, '0, 1, 0);
        rd("R9", 20, 21);
        chk("R9", "write before restore", rs1_data, 32'h9999_0014);
        step("R6", 0, 0, 0, 0, '0, 0, 1);

        // R7 fill all windows then overflow twice
        for (int i = 0; i < NW - 2; i++) step("R7", 0, 0, 0, 0, '0, 1, 0);
        step("R7", 0, 0, 0, 0, '0, 1, 0);
        step("R7", 0, 0, 1, 17, 32'hABCD_0011, 1, 0);
        rd("R7", 17, 0);
        // R10 save wins over restore
        step("R10", 0, 0, 0, 0, '0, 1, 1);
        step("R10", 0, 0, 0, 0, '0, 0, 1);
        step("R10", 0, 0, 0, 0, '0, 1, 1);
        // R8 empty then underflow
        for (int i = 0; i < NW; i++) step("R8", 0, 0, 0, 0, '0, 0, 1);
        step("R8", 0, 0, 0, 0, '0, 0, 1);

        // constrained random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int a, b, w, op;
            a  = int'($urandom_range(0, 31));
            b  = int'($urandom_range(0, 31));
            w  = int'($urandom_range(0, 31));
            op = int'($urandom_range(0, 7));
            step("R1", a, b, $urandom_range(0, 1) == 1, w, $urandom(),
                 op == 0 || op == 1 || op == 6, op == 2 || op == 3 || op == 6);
        end

        finish_run();
    end

endmodule